// File: doc/BRIEF.md
# Bidirectional Threshold Alert and Fault Engine

This block watches a stream of signed current samples and two unsigned power samples (peak and average). It splits the signed current into a positive-flow and a reverse-flow magnitude, which gives four monitored channels. Each channel has its own programmable assert level and its own release level. The gap between the two levels is the channel's hysteresis band. A crossing counts only after it has been seen on N consecutive sample ticks. A channel that stays above its assert level escalates in steps of N ticks: first to a low alert, then to a high alert, then to a trip that latches a fault.

The engine drives three outputs:
- ALERT is a recoverable warning. It re-arms by itself and is stretched by a hold time.
- FAULT is a protective trip. It stays latched until software clears it, or until the channel releases when auto-clear is on.
- PG means operable. It is low whenever any fault bit is set.

Per-channel alert and fault source bits, together with a one-entry event capture (code plus sample-tick timestamp), let software tell an early warning from a hard trip.

Top module: `thr_alert_engine`

## Requirements
- R1: Channel 0 takes the current when it is positive, else 0. Channel 1 takes the negated current when it is negative, else 0, so -32768 maps to 32768. Channel 2 takes peak power and channel 3 takes average power. All compares are unsigned against 16-bit levels taken from `set_lvl_i`/`rel_lvl_i` bits [16c+15:16c].
- R2: A magnitude at or above the assert level must be seen on N consecutive ticks (`deb_n_i`, where 0 acts as 1) before the stage steps up. A tick in the band, or below the release level, restarts the count.
- R3: A magnitude below the release level on N consecutive ticks returns an active channel to idle. Ticks inside the band keep the stage and restart both counts.
- R4: The stages are idle (0), low alert (1), high alert (2) and trip (3). Each further run of N above-level ticks moves up one stage. Entering trip sets the channel's bit in `fault_src_o`.
- R5: A fault bit stays set until a pulse on `clr_fault_i[c]` clears it. The clear is refused while that channel is in trip. `fault_o` is the OR of the fault bits.
- R6: With `auto_clr_i` high, a fault bit also clears as soon as its channel is idle.
- R7: `pg_o` is low exactly while some fault bit is set. Alert stages do not lower it.
- R8: `alert_o` is high while any channel is in stage 1 or 2. After the last such channel leaves those stages, `alert_o` stays high until `hold_n_i` further sample ticks have passed.
- R9: With `latch_edge_i` low, `alert_src_o[c]` shows whether channel c is in stage 1 or 2. With it high, the bit becomes sticky once set: it stays set until `clr_alert_i[c]` is pulsed while the channel is outside stages 1 and 2, and it also keeps `alert_o` high.
- R10: On any tick where some channel steps up, `evt_stb_o` pulses for one cycle. `evt_code_o` is {new stage[3:2], channel[1:0]}, chosen by highest new stage and then lowest channel number. `evt_time_o` holds the tick count since reset, with the first tick being 0.
- R11: Cycles without `smp_vld_i` leave the stages, the counts and the timestamp unchanged, whatever the sample inputs carry.
- R12: After reset, all stages are idle and all bits are clear, `pg_o` is high, and the event code and event time are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample tick; the sample inputs are valid |
| cur_i | input | 16 | Signed current sample |
| ppk_i | input | 16 | Peak power sample |
| pavg_i | input | 16 | Average power sample |
| set_lvl_i | input | 64 | Assert levels, 16 bits per channel |
| rel_lvl_i | input | 64 | Release levels, 16 bits per channel |
| deb_n_i | input | 8 | Consecutive-tick count N |
| hold_n_i | input | 8 | Alert hold time in ticks |
| latch_edge_i | input | 1 | 1 makes the alert source bits sticky |
| auto_clr_i | input | 1 | 1 clears fault bits when the channel is idle |
| clr_fault_i | input | 4 | Write-one-to-clear pulses for the fault bits |
| clr_alert_i | input | 4 | Write-one-to-clear pulses for the sticky alert bits |
| alert_o | output | 1 | Recoverable alert |
| fault_o | output | 1 | Latched protective fault |
| pg_o | output | 1 | Power good / operable |
| alert_src_o | output | 4 | Alert source bits |
| fault_src_o | output | 4 | Fault source bits |
| evt_stb_o | output | 1 | Event captured this cycle |
| evt_code_o | output | 4 | Captured event code |
| evt_time_o | output | 16 | Captured tick timestamp |

## Verification
The hardest state to reach from the ports is a tie: two or more channels stepping up on the very same tick, at the same or at different stages. Only in that case does the priority choice in the event code matter. The stimulus reaches it by raising the current and both power inputs together, so that their debounce runs start on the same tick. A later long random phase sweeps all inputs around the levels, with changing N, hold time, clear pulses and mode bits. Throughout, a behavioural model built on integer arrays is compared against every output on every clock. The refused clear during a trip is provoked directly by pulsing the clear while the channel is still above its level.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int NCH     = 4;
    localparam int CH_POS  = 0;
    localparam int CH_NEG  = 1;
    localparam int CH_PEAK = 2;
    localparam int CH_AVG  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARN  = 2'd1,
        ST_ALARM = 2'd2,
        ST_TRIP  = 2'd3
    } stage_e;
endpackage

// File: rtl/thr_chan.sv
// One monitored channel: debounced hysteresis compare and stage escalation.
module thr_chan
    import thr_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic [DW-1:0] mag_i,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] rel_i,
    input  logic [CW-1:0] nlim_i,
    input  logic          clr_i,
    input  logic          auto_clr_i,
    output logic [1:0]    stage_q_o,
    output logic [1:0]    stage_d_o,
    output logic          fault_o,
    output logic          esc_o
);
    typedef struct packed {
        stage_e        stg;
        logic [CW-1:0] up;
        logic [CW-1:0] dn;
        logic          flt;
    } chan_s;

    chan_s         ch_d, ch_q;
    logic [CW-1:0] n_eff;
    logic [CW-1:0] up_inc;
    logic [CW-1:0] dn_inc;

    always_comb begin
        n_eff  = (nlim_i == '0) ? CW'(1) : nlim_i;
        up_inc = ch_q.up + 1'b1;
        dn_inc = ch_q.dn + 1'b1;
        ch_d   = ch_q;
        esc_o  = 1'b0;
        if (tick_i) begin
            if (mag_i >= set_i) begin
                ch_d.dn = '0;
                if (ch_q.stg == ST_TRIP) begin
                    ch_d.up = '0;
                end else if (up_inc == n_eff) begin
                    ch_d.stg = stage_e'(2'(ch_q.stg) + 2'd1);
                    ch_d.up  = '0;
                    esc_o    = 1'b1;
                end else begin
                    ch_d.up = up_inc;
                end
            end else if (mag_i < rel_i) begin
                ch_d.up = '0;
                if (ch_q.stg == ST_IDLE) begin
                    ch_d.dn = '0;
                end else if (dn_inc == n_eff) begin
                    ch_d.stg = ST_IDLE;
                    ch_d.dn  = '0;
                end else begin
                    ch_d.dn = dn_inc;
                end
            end else begin
                ch_d.up = '0;
                ch_d.dn = '0;
            end
        end
        if (ch_d.stg == ST_TRIP) begin
            ch_d.flt = 1'b1;
        end else if (clr_i && (ch_q.stg != ST_TRIP)) begin
            ch_d.flt = 1'b0;
        end else if (auto_clr_i && (ch_d.stg == ST_IDLE)) begin
            ch_d.flt = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ch_q <= '{stg: ST_IDLE, up: '0, dn: '0, flt: 1'b0};
        end else begin
            ch_q <= ch_d;
        end
    end

    assign stage_q_o = ch_q.stg;
    assign stage_d_o = ch_d.stg;
    assign fault_o   = ch_q.flt;
endmodule

// File: rtl/thr_evt_pick.sv
// Fixed-priority choice among channels stepping up on the same tick.
module thr_evt_pick #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]       esc_i,
    input  logic [NCH-1:0][1:0]  stg_i,
    output logic                 hit_o,
    output logic [CHW+1:0]       code_o
);
    logic [1:0]     best;
    logic [CHW-1:0] bch;

    always_comb begin
        best = '0;
        bch  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (esc_i[c] && (stg_i[c] > best)) begin
                best = stg_i[c];
                bch  = CHW'(c);
            end
        end
        hit_o  = (best != '0);
        code_o = {best, bch};
    end
endmodule

// File: rtl/thr_hold.sv
// Alert stretch timer counted in sample ticks.
module thr_hold #(
    parameter int HW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          act_now_i,
    input  logic          act_prev_i,
    input  logic [HW-1:0] hold_i,
    output logic          busy_o
);
    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (act_now_i || act_prev_i) begin
            cnt_d = hold_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/thr_alert_engine.sv
// Top: four threshold channels, alert hold, sticky sources and event capture.
module thr_alert_engine
    import thr_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 8,
    parameter int HW = 8,
    parameter int TW = 16,
    localparam int CHW   = $clog2(NCH),
    localparam int CODEW = CHW + 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  smp_vld_i,
    input  logic signed [DW-1:0]  cur_i,
    input  logic [DW-1:0]         ppk_i,
    input  logic [DW-1:0]         pavg_i,
    input  logic [NCH*DW-1:0]     set_lvl_i,
    input  logic [NCH*DW-1:0]     rel_lvl_i,
    input  logic [CW-1:0]         deb_n_i,
    input  logic [HW-1:0]         hold_n_i,
    input  logic                  latch_edge_i,
    input  logic                  auto_clr_i,
    input  logic [NCH-1:0]        clr_fault_i,
    input  logic [NCH-1:0]        clr_alert_i,
    output logic                  alert_o,
    output logic                  fault_o,
    output logic                  pg_o,
    output logic [NCH-1:0]        alert_src_o,
    output logic [NCH-1:0]        fault_src_o,
    output logic                  evt_stb_o,
    output logic [CODEW-1:0]      evt_code_o,
    output logic [TW-1:0]         evt_time_o
);
    typedef struct packed {
        logic [NCH-1:0]   stk;
        logic [TW-1:0]    ts;
        logic             stb;
        logic [CODEW-1:0] code;
        logic [TW-1:0]    tm;
    } top_s;

    logic [NCH-1:0][DW-1:0] mag;
    logic [NCH-1:0][1:0]    stg_q, stg_d;
    logic [NCH-1:0]         flt, esc;
    logic [NCH-1:0]         lvl_q, lvl_d;
    logic [DW-1:0]          cur_u;
    logic                   hit;
    logic [CODEW-1:0]       pick_code;
    logic                   hold_busy;
    top_s                   r_d, r_q;

    assign cur_u = cur_i;

    always_comb begin
        mag          = '0;
        mag[CH_POS]  = cur_u[DW-1] ? '0 : cur_u;
        mag[CH_NEG]  = cur_u[DW-1] ? (~cur_u + 1'b1) : '0;
        mag[CH_PEAK] = ppk_i;
        mag[CH_AVG]  = pavg_i;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        thr_chan #(.DW(DW), .CW(CW)) u_ch (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .tick_i     (smp_vld_i),
            .mag_i      (mag[c]),
            .set_i      (set_lvl_i[c*DW +: DW]),
            .rel_i      (rel_lvl_i[c*DW +: DW]),
            .nlim_i     (deb_n_i),
            .clr_i      (clr_fault_i[c]),
            .auto_clr_i (auto_clr_i),
            .stage_q_o  (stg_q[c]),
            .stage_d_o  (stg_d[c]),
            .fault_o    (flt[c]),
            .esc_o      (esc[c])
        );
        assign lvl_q[c] = (stg_q[c] == ST_WARN) || (stg_q[c] == ST_ALARM);
        assign lvl_d[c] = (stg_d[c] == ST_WARN) || (stg_d[c] == ST_ALARM);
    end

    thr_evt_pick #(.NCH(NCH)) u_pick (
        .esc_i  (esc),
        .stg_i  (stg_d),
        .hit_o  (hit),
        .code_o (pick_code)
    );

    thr_hold #(.HW(HW)) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (smp_vld_i),
        .act_now_i  (|lvl_d),
        .act_prev_i (|lvl_q),
        .hold_i     (hold_n_i),
        .busy_o     (hold_busy)
    );

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (latch_edge_i && lvl_d[c]) begin
                r_d.stk[c] = 1'b1;
            end else if (clr_alert_i[c] && !lvl_q[c]) begin
                r_d.stk[c] = 1'b0;
            end
        end
        if (hit) begin
            r_d.stb  = 1'b1;
            r_d.code = pick_code;
            r_d.tm   = r_q.ts;
        end
        if (smp_vld_i) begin
            r_d.ts = r_q.ts + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fault_src_o = flt;
    assign fault_o     = |flt;
    assign pg_o        = ~(|flt);
    assign alert_src_o = latch_edge_i ? r_q.stk : lvl_q;
    assign alert_o     = (|lvl_q) | hold_busy | (latch_edge_i & (|r_q.stk));
    assign evt_stb_o   = r_q.stb;
    assign evt_code_o  = r_q.code;
    assign evt_time_o  = r_q.tm;
endmodule

// File: rtl/thr_alert_checker.sv
// Protocol properties of the alert engine, bound to the top module.
module thr_alert_checker
    import thr_pkg::*;
(
    input logic           clk_i,
    input logic           rst_ni,
    input logic           smp_vld_i,
    input logic           auto_clr_i,
    input logic [NCH-1:0] clr_fault_i,
    input logic           pg_o,
    input logic [NCH-1:0] fault_src_o,
    input logic           evt_stb_o,
    input logic [3:0]     evt_code_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R4: a fault bit can only appear as the result of a sample tick
        a_r4_fault_rises_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(fault_src_o[c]) |-> $past(smp_vld_i));
        // R5 / R6: a fault bit drops only after a clear pulse or with auto-clear on
        a_r5_fault_falls_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(fault_src_o[c]) |-> $past(clr_fault_i[c] || auto_clr_i));
    end

    // R7: a set fault bit in any channel forces PG low
    a_r7_pg_low_in_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fault_src_o != '0) |-> !pg_o);

    // R10: an event is captured only after a sample tick
    a_r10_event_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_stb_o |-> $past(smp_vld_i));

    // R10: a captured event never carries the idle stage
    a_r10_event_stage_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_stb_o |-> (evt_code_o[3:2] != 2'd0));

    // R10: the strobe lasts a single cycle unless ticks come back to back
    a_r10_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_stb_o && !smp_vld_i) |=> !evt_stb_o);
endmodule

bind thr_alert_engine thr_alert_checker u_thr_chk (.*);

// File: tb/tb_thr_alert_engine.sv
module tb_thr_alert_engine;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               vld = 1'b0;
    logic signed [15:0] cur = '0;
    logic [15:0]        ppk = '0;
    logic [15:0]        pavg = '0;
    logic [63:0]        set_lvl = '0;
    logic [63:0]        rel_lvl = '0;
    logic [7:0]         deb = 8'd3;
    logic [7:0]         hold = 8'd4;
    logic               latch_edge = 1'b0;
    logic               auto_clr = 1'b0;
    logic [3:0]         clr_f = '0;
    logic [3:0]         clr_a = '0;
    logic               alert, fault, pg, stb;
    logic [3:0]         asrc, fsrc, code;
    logic [15:0]        etime;

    always #5 clk = ~clk;

    thr_alert_engine dut (
        .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .cur_i(cur), .ppk_i(ppk),
        .pavg_i(pavg), .set_lvl_i(set_lvl), .rel_lvl_i(rel_lvl), .deb_n_i(deb),
        .hold_n_i(hold), .latch_edge_i(latch_edge), .auto_clr_i(auto_clr),
        .clr_fault_i(clr_f), .clr_alert_i(clr_a), .alert_o(alert), .fault_o(fault),
        .pg_o(pg), .alert_src_o(asrc), .fault_src_o(fsrc), .evt_stb_o(stb),
        .evt_code_o(code), .evt_time_o(etime)
    );

    // behavioural reference state
    int    tset [4] = '{1000, 500, 2000, 1200};
    int    trel [4] = '{800, 300, 1500, 1000};
    int    mst [4], mup [4], mdn [4];
    bit    mflt [4], mstk [4];
    int    mhold, mts, mcode, mtime;
    bit    mstb;
    int    vectors = 0;
    int    errors = 0;
    string phase = "R12 reset state";

    function automatic int mag_of(int c);
        int ci = int'(cur);
        case (c)
            0: return (ci > 0) ? ci : 0;
            1: return (ci < 0) ? -ci : 0;
            2: return int'(ppk);
            default: return int'(pavg);
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            mst[c] = 0; mup[c] = 0; mdn[c] = 0; mflt[c] = 0; mstk[c] = 0;
        end
        mhold = 0; mts = 0; mcode = 0; mtime = 0; mstb = 0;
    endtask

    task automatic model_clock();
        int  nst [4];
        bit  esc [4];
        int  n, best, bch, m;
        bit  old_al, new_al;
        if (!rst_n) begin
            model_reset();
            return;
        end
        n = (deb == 0) ? 1 : int'(deb);
        for (int c = 0; c < 4; c++) begin
            nst[c] = mst[c];
            esc[c] = 0;
            m = mag_of(c);
            if (vld) begin
                if (m >= tset[c]) begin
                    mdn[c] = 0;
                    if (mst[c] == 3) mup[c] = 0;
                    else begin
                        mup[c]++;
                        if (mup[c] == n) begin nst[c] = mst[c] + 1; mup[c] = 0; esc[c] = 1; end
                    end
                end else if (m < trel[c]) begin
                    mup[c] = 0;
                    if (mst[c] == 0) mdn[c] = 0;
                    else begin
                        mdn[c]++;
                        if (mdn[c] == n) begin nst[c] = 0; mdn[c] = 0; end
                    end
                end else begin
                    mup[c] = 0; mdn[c] = 0;
                end
            end
            if (nst[c] == 3) mflt[c] = 1;
            else if (clr_f[c] && mst[c] != 3) mflt[c] = 0;
            else if (auto_clr && nst[c] == 0) mflt[c] = 0;
            if (latch_edge && (nst[c] == 1 || nst[c] == 2)) mstk[c] = 1;
            else if (clr_a[c] && !(mst[c] == 1 || mst[c] == 2)) mstk[c] = 0;
        end
        old_al = 0; new_al = 0;
        for (int c = 0; c < 4; c++) begin
            if (mst[c] == 1 || mst[c] == 2) old_al = 1;
            if (nst[c] == 1 || nst[c] == 2) new_al = 1;
        end
        if (new_al || old_al) mhold = int'(hold);
        else if (vld && mhold > 0) mhold--;
        best = 0; bch = 0;
        for (int c = 0; c < 4; c++)
            if (esc[c] && nst[c] > best) begin best = nst[c]; bch = c; end
        mstb = (best != 0);
        if (mstb) begin mcode = best * 4 + bch; mtime = mts; end
        if (vld) mts = (mts + 1) % 65536;
        for (int c = 0; c < 4; c++) mst[c] = nst[c];
    endtask

    task automatic chk(string req, int got, int exp);
        if (got != exp) begin
            errors++;
            $display("FAIL %s [%s] got %0d expected %0d at %0t", phase, req, got, exp, $time);
        end
    endtask

    task automatic compare();
        int  e_asrc, e_fsrc;
        bit  e_alert, any_lvl, any_stk;
        e_asrc = 0; e_fsrc = 0; any_lvl = 0; any_stk = 0;
        for (int c = 0; c < 4; c++) begin
            if (mst[c] == 1 || mst[c] == 2) any_lvl = 1;
            if (mstk[c]) any_stk = 1;
            if (mflt[c]) e_fsrc |= (1 << c);
            if (latch_edge ? mstk[c] : (mst[c] == 1 || mst[c] == 2)) e_asrc |= (1 << c);
        end
        e_alert = any_lvl || (mhold > 0) || (latch_edge && any_stk);
        vectors++;
        chk("R8 alert_o", int'(alert), int'(e_alert));
        chk("R5 fault_o", int'(fault), int'(e_fsrc != 0));
        chk("R7 pg_o", int'(pg), int'(e_fsrc == 0));
        chk("R9 alert_src_o", int'(asrc), e_asrc);
        chk("R4 fault_src_o", int'(fsrc), e_fsrc);
        chk("R10 evt_stb_o", int'(stb), int'(mstb));
        chk("R10 evt_code_o", int'(code), mcode);
        chk("R10 evt_time_o", int'(etime), mtime);
    endtask

    task automatic step();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare();
        clr_f = '0;
        clr_a = '0;
    endtask

    task automatic samp(int c_v, int p_v, int a_v, int reps);
        for (int i = 0; i < reps; i++) begin
            vld = 1'b1; cur = 16'(c_v); ppk = 16'(p_v); pavg = 16'(a_v);
            step();
        end
    endtask

    task automatic idle(int reps, int junk);
        for (int i = 0; i < reps; i++) begin
            vld = 1'b0; cur = 16'(junk); ppk = 16'(junk); pavg = 16'(junk);
            step();
        end
    endtask

    task automatic quiet_all();
        samp(0, 0, 0, 6);
        clr_f = 4'hF; clr_a = 4'hF;
        idle(1, 0);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            set_lvl[c*16 +: 16] = 16'(tset[c]);
            rel_lvl[c*16 +: 16] = 16'(trel[c]);
        end
        model_reset();
        repeat (3) step();
        rst_n = 1'b1;
        idle(2, 0);                                  // R12 reset state

        phase = "R2 debounce";
        samp(1100, 0, 0, 2);
        samp(900, 0, 0, 1);                          // in band: count restarts
        samp(1100, 0, 0, 3);                         // low alert on the third tick

        phase = "R11 gaps without sample tick";
        idle(3, 30000);
        clr_a = 4'hF;
        idle(1, -5000);

        phase = "R4 escalation to trip";
        samp(1100, 0, 0, 6);

        phase = "R5 refused clear while tripped";
        clr_f = 4'h1;
        samp(1100, 0, 0, 1);
        samp(700, 0, 0, 3);
        idle(2, 0);
        clr_f = 4'h1;
        idle(2, 0);

        phase = "R3 hysteresis band on reverse flow";
        samp(-600, 0, 0, 3);
        samp(-400, 0, 0, 5);
        samp(-200, 0, 0, 3);
        samp(0, 0, 0, 6);                            // R8 hold stretch

        phase = "R1 extreme reverse and power channels";
        samp(-32768, 2500, 0, 9);
        samp(0, 0, 1300, 4);
        quiet_all();

        phase = "R10 simultaneous escalation priority";
        samp(1100, 2500, 1300, 3);
        samp(1100, 2500, 0, 4);
        samp(-600, 2500, 1300, 3);
        quiet_all();

        phase = "R9 sticky alert sources";
        latch_edge = 1'b1;
        samp(1100, 0, 0, 3);
        samp(0, 0, 0, 8);
        clr_a = 4'h1;
        samp(0, 0, 0, 2);
        latch_edge = 1'b0;
        samp(0, 0, 0, 2);

        phase = "R6 auto clear";
        auto_clr = 1'b1;
        samp(0, 0, 1300, 9);
        samp(0, 0, 1100, 2);
        samp(0, 0, 0, 4);
        auto_clr = 1'b0;

        phase = "R2 count zero acts as one";
        deb = 8'd0;
        samp(1100, 0, 0, 1);
        samp(0, 0, 0, 2);
        deb = 8'd3;
        quiet_all();

        phase = "R1 random sweep";
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            vld = (r < 75);
            cur = (r == 3) ? 16'sh8000 : 16'($signed($urandom_range(0, 3000)) - 1500);
            ppk = 16'($urandom_range(0, 2600));
            pavg = 16'($urandom_range(0, 1600));
            if ($urandom_range(0, 19) == 0) clr_f = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 19) == 0) clr_a = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 199) == 0) begin
                latch_edge = ~latch_edge;
                auto_clr   = 1'($urandom_range(0, 1));
                deb        = 8'($urandom_range(0, 4));
                hold       = 8'($urandom_range(0, 5));
            end
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog [R12] got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule